// File: doc/BRIEF.md
# Four-Activate Window Throttle

This block sits next to the bank scheduler of one DRAM rank and decides, every cycle, whether an activate may be sent and whether a row-conflict precharge is worth sending yet. It remembers the issue times of the most recent activates in a small circular history. From the oldest of those times it works out the earliest cycle at which the rank's four-activate window lets another activate through.

A row-conflict precharge only helps if the activate behind it can follow promptly. When the window will block that activate for longer than the precharge takes, closing the row early gains nothing and throws away any chance of further hits to it. So the block holds such a precharge back until the current cycle plus the precharge time reaches the next legal activate slot. The scheduler supplies a free-running cycle counter that advances by one every clock. It raises `act_issued` in the cycle an activate goes out, and `pre_candidate` while it has a row-conflict precharge ready.

Top module: `act_window_throttle`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it, the history is empty: `act_allowed` is 1 and `pre_allowed` equals `pre_candidate`.
- R2: While fewer than NACT activates have been recorded since reset, `act_allowed` is 1 and `pre_allowed` equals `pre_candidate`.
- R3: Once NACT activates have been recorded, `act_allowed` is 1 exactly when the cycles elapsed since the oldest recorded activate are at least TFAW. The elapsed count is taken modulo 2^CNT_W of `cycle_cnt`. The scheduler raises `act_issued` only when `act_allowed` is 1.
- R4: The history keeps the NACT most recent activates. Each new activate replaces the oldest entry, and the next oldest becomes the reference.
- R5: Once NACT activates have been recorded, `pre_allowed` is 1 exactly when `pre_candidate` is 1 and the elapsed cycles plus TRP are at least TFAW.
- R6: `pre_allowed` is 0 in every cycle in which `pre_candidate` is 0.
- R7: The decisions stay correct when `cycle_cnt` wraps. An entry that has once become legal stays legal until it is overwritten, even after an idle stretch longer than 2^CNT_W cycles.
- R8: An activate raised in cycle c is stamped with the `cycle_cnt` value of cycle c. It does not affect the outputs of cycle c, and it takes part in the decisions from cycle c+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cycle_cnt | input | CNT_W | Free-running cycle count, one step per clock |
| act_issued | input | 1 | An activate is sent to the rank this cycle |
| pre_candidate | input | 1 | A row-conflict precharge is ready this cycle |
| act_allowed | output | 1 | The four-activate window admits an activate now |
| pre_allowed | output | 1 | The pending precharge may be sent now |

## Verification
The bench builds the block with NACT=4, TFAW=20, TRP=6 and a 6-bit cycle counter. The 6-bit counter wraps every 64 cycles, so wrap-around and idle stretches longer than the counter's range are reached many times in a short run. A 20-cycle window with a 6-cycle precharge leaves a 6-cycle span in which a precharge is allowed but an activate is not. Both exact boundary cycles are stepped through in every burst of activates.

// File: rtl/act_thr_pkg.sv
package act_thr_pkg;

  // Lead test: has elapsed + lead reached the window length?
  function automatic logic lead_reaches(input logic [63:0] elapsed,
                                        input logic [63:0] lead,
                                        input logic [63:0] window);
    return (elapsed + lead) >= window;
  endfunction

  // Next pointer in a ring of n slots
  function automatic int unsigned ring_next(input int unsigned ptr,
                                            input int unsigned n);
    return (ptr + 1 >= n) ? 0 : ptr + 1;
  endfunction

endpackage

// File: rtl/act_thr_entry.sv
module act_thr_entry
  import act_thr_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int TFAW  = 32,
  parameter int TRP   = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cycle_cnt,
  input  logic             wr_en,
  output logic             legal_o,
  output logic             pre_ok_o
);
  logic [CNT_W-1:0] stamp_q;
  logic             aged_q;
  logic [CNT_W-1:0] elapsed;
  logic             win_done;
  logic             pre_done;

  assign elapsed  = cycle_cnt - stamp_q;
  assign win_done = lead_reaches(64'(elapsed), 64'd0, 64'(TFAW));
  assign pre_done = lead_reaches(64'(elapsed), 64'(TRP), 64'(TFAW));

  // aged_q latches legality so a later counter wrap cannot revoke it
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stamp_q <= '0;
      aged_q  <= 1'b0;
    end else if (wr_en) begin
      stamp_q <= cycle_cnt;
      aged_q  <= 1'b0;
    end else if (win_done) begin
      aged_q  <= 1'b1;
    end
  end

  assign legal_o  = aged_q | win_done;
  assign pre_ok_o = aged_q | pre_done;

  assert_aged_sticky_R7 : assert property (@(posedge clk) disable iff (!rst_n)
    (aged_q && !wr_en) |=> aged_q);

  assert_fresh_blocked_R8 : assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !aged_q);

endmodule

// File: rtl/act_thr_ring.sv
module act_thr_ring
  import act_thr_pkg::*;
#(
  parameter int NACT  = 4,
  parameter int CNT_W = 16,
  parameter int TFAW  = 32,
  parameter int TRP   = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cycle_cnt,
  input  logic             act_issued,
  output logic             full_o,
  output logic             oldest_legal_o,
  output logic             oldest_pre_ok_o
);
  localparam int PTR_W  = (NACT > 1) ? $clog2(NACT) : 1;
  localparam int FILL_W = $clog2(NACT + 1);

  logic [PTR_W-1:0]  wr_ptr_q;
  logic [FILL_W-1:0] fill_q;
  logic [NACT-1:0]   wr_vec;
  logic [NACT-1:0]   legal_vec;
  logic [NACT-1:0]   pre_vec;

  genvar gi;
  generate
    for (gi = 0; gi < NACT; gi++) begin : g_slot
      assign wr_vec[gi] = act_issued && (wr_ptr_q == PTR_W'(gi));
      act_thr_entry #(
        .CNT_W (CNT_W),
        .TFAW  (TFAW),
        .TRP   (TRP)
      ) i_entry (
        .clk       (clk),
        .rst_n     (rst_n),
        .cycle_cnt (cycle_cnt),
        .wr_en     (wr_vec[gi]),
        .legal_o   (legal_vec[gi]),
        .pre_ok_o  (pre_vec[gi])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      fill_q   <= '0;
    end else if (act_issued) begin
      wr_ptr_q <= PTR_W'(ring_next(int'(wr_ptr_q), NACT));
      if (fill_q != FILL_W'(NACT)) fill_q <= fill_q + 1'b1;
    end
  end

  // When full, the write slot holds the oldest activate
  always_comb begin
    oldest_legal_o  = 1'b1;
    oldest_pre_ok_o = 1'b1;
    for (int k = 0; k < NACT; k++) begin
      if (wr_ptr_q == PTR_W'(k)) begin
        oldest_legal_o  = legal_vec[k];
        oldest_pre_ok_o = pre_vec[k];
      end
    end
  end

  assign full_o = (fill_q == FILL_W'(NACT));

  assert_fill_bound_R4 : assert property (@(posedge clk) disable iff (!rst_n)
    fill_q <= FILL_W'(NACT));

  assert_one_writer_R4 : assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_vec));

  assert_fill_by_issue_R8 : assert property (@(posedge clk) disable iff (!rst_n)
    $rose(full_o) |-> $past(act_issued));

endmodule

// File: rtl/act_thr_decide.sv
module act_thr_decide (
  input  logic clk,
  input  logic rst_n,
  input  logic full,
  input  logic oldest_legal,
  input  logic oldest_pre_ok,
  input  logic pre_candidate,
  output logic act_allowed,
  output logic pre_allowed
);
  logic pre_slot_near;

  assign act_allowed   = !full || oldest_legal;
  assign pre_slot_near = !full || oldest_pre_ok;
  assign pre_allowed   = pre_candidate && pre_slot_near;

  assert_cand_gate_R6 : assert property (@(posedge clk) disable iff (!rst_n)
    !pre_candidate |-> !pre_allowed);

  assert_open_when_short_R2 : assert property (@(posedge clk) disable iff (!rst_n)
    !full |-> act_allowed);

  assert_pre_not_later_R5 : assert property (@(posedge clk) disable iff (!rst_n)
    (pre_candidate && act_allowed) |-> pre_allowed);

endmodule

// File: rtl/act_window_throttle.sv
module act_window_throttle #(
  parameter int NACT  = 4,
  parameter int CNT_W = 16,
  parameter int TFAW  = 32,
  parameter int TRP   = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cycle_cnt,
  input  logic             act_issued,
  input  logic             pre_candidate,
  output logic             act_allowed,
  output logic             pre_allowed
);
  logic hist_full;
  logic oldest_legal;
  logic oldest_pre_ok;

  act_thr_ring #(
    .NACT  (NACT),
    .CNT_W (CNT_W),
    .TFAW  (TFAW),
    .TRP   (TRP)
  ) i_ring (
    .clk             (clk),
    .rst_n           (rst_n),
    .cycle_cnt       (cycle_cnt),
    .act_issued      (act_issued),
    .full_o          (hist_full),
    .oldest_legal_o  (oldest_legal),
    .oldest_pre_ok_o (oldest_pre_ok)
  );

  act_thr_decide i_decide (
    .clk           (clk),
    .rst_n         (rst_n),
    .full          (hist_full),
    .oldest_legal  (oldest_legal),
    .oldest_pre_ok (oldest_pre_ok),
    .pre_candidate (pre_candidate),
    .act_allowed   (act_allowed),
    .pre_allowed   (pre_allowed)
  );

  assert_issue_in_window_R3 : assert property (@(posedge clk) disable iff (!rst_n)
    act_issued |-> act_allowed);

  assert_count_steps_R7 : assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) || (cycle_cnt == CNT_W'($past(cycle_cnt) + 1'b1)));

endmodule

// File: tb/test_act_window_throttle.sv
module test_act_window_throttle;
  localparam int NA  = 4;
  localparam int CW  = 6;
  localparam int WIN = 20;
  localparam int PT  = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [CW-1:0] cnt = '0;
  logic          act_issued = 1'b0;
  logic          pre_candidate = 1'b0;
  logic          act_allowed;
  logic          pre_allowed;

  int t_abs = 0;
  int hist[NA];
  int n_rec = 0;
  int head = 0;
  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cnt   <= cnt + 1'b1;
    t_abs <= t_abs + 1;
  end

  act_window_throttle #(
    .NACT  (NA),
    .CNT_W (CW),
    .TFAW  (WIN),
    .TRP   (PT)
  ) i_act_window_throttle (
    .clk           (clk),
    .rst_n         (rst_n),
    .cycle_cnt     (cnt),
    .act_issued    (act_issued),
    .pre_candidate (pre_candidate),
    .act_allowed   (act_allowed),
    .pre_allowed   (pre_allowed)
  );

  function automatic bit exp_act();
    if (n_rec < NA) return 1'b1;
    return (t_abs - hist[head]) >= WIN;
  endfunction

  function automatic bit exp_pre(input bit cand);
    if (!cand) return 1'b0;
    if (n_rec < NA) return 1'b1;
    return (t_abs - hist[head]) + PT >= WIN;
  endfunction

  task automatic chk(input bit got, input bit exp, input string req, input string what);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0b expected=%0b at t=%0d", req, what, got, exp, t_abs);
    end
  endtask

  // One cycle: drive at negedge, check, update model
  task automatic step(input bit want_act, input bit cand, input string tag);
    bit ea, ep;
    string ta, tp;
    @(negedge clk);
    pre_candidate = cand;
    ea = exp_act();
    ep = exp_pre(cand);
    act_issued = want_act && ea;
    #1;
    ta = (tag != "") ? tag : ((n_rec < NA) ? "R2" : "R3");
    tp = (tag != "") ? tag : (!cand ? "R6" : ((n_rec < NA) ? "R2" : "R5"));
    chk(act_allowed, ea, ta, "act_allowed");
    chk(pre_allowed, ep, tp, "pre_allowed");
    if (act_issued) begin
      hist[head] = t_abs;
      head = (head + 1) % NA;
      if (n_rec < NA) n_rec++;
    end
  endtask

  task automatic wait_legal(input string tag);
    int guard = 0;
    while (!exp_act() && guard < 100) begin
      step(1'b0, 1'b1, tag);
      guard++;
    end
  endtask

  initial begin
    bit seed_dummy;
    seed_dummy = 1'($urandom(32'h5eed_1234));
    // R1: reset state
    repeat (3) @(negedge clk);
    pre_candidate = 1'b0;
    #1;
    chk(act_allowed, 1'b1, "R1", "act_allowed in reset");
    chk(pre_allowed, 1'b0, "R1", "pre_allowed in reset, no candidate");
    pre_candidate = 1'b1;
    #1;
    chk(pre_allowed, 1'b1, "R1", "pre_allowed in reset, candidate");
    @(negedge clk);
    rst_n = 1'b1;
    step(1'b0, 1'b1, "R1");

    // R2: partial history stays open
    for (int i = 0; i < NA - 1; i++) step(1'b1, 1'b1, "R2");
    repeat (3) step(1'b0, 1'b1, "R2");

    // R8: last filling activate does not change its own cycle
    step(1'b1, 1'b1, "R8");
    step(1'b0, 1'b1, "R8");

    // R3 / R5 boundaries: walk to the first legal slot cycle by cycle
    wait_legal("");
    // R4: new activate replaces oldest, reference moves to next oldest
    step(1'b1, 1'b0, "R4");
    for (int i = 0; i < 8; i++) step(1'b0, 1'b1, "R4");
    wait_legal("R4");

    // Back-to-back burst, then boundary walk
    for (int i = 0; i < NA; i++) begin
      wait_legal("R3");
      step(1'b1, 1'b1, "R3");
    end
    for (int i = 0; i < WIN + 2; i++) step(1'b0, 1'b1, "");

    // R7: idle far beyond counter range, legality must hold
    for (int i = 0; i < 3 * (1 << CW) + 7; i++) step(1'b0, i[0], "R7");
    for (int i = 0; i < NA; i++) step(1'b1, 1'b1, "R7");
    for (int i = 0; i < 2 * (1 << CW); i++) step(1'b0, 1'b1, "R7");

    // Random traffic
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = int'($urandom_range(0, 99));
      if (r < 4) begin
        int idle;
        idle = int'($urandom_range(10, 90));
        for (int k = 0; k < idle; k++) step(1'b0, 1'b1, "");
      end else begin
        step($urandom_range(0, 2) == 0, $urandom_range(0, 3) != 0, "");
      end
    end

    act_issued = 1'b0;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule